// File: doc/BRIEF.md
# Load-Use Stall and Early Branch Resolution Control

This block is the hazard controller of a five-stage in-order pipeline. It watches the instruction sitting in decode and the one just issued to execute. If the execute-stage instruction is a load whose destination register is a source of the decode-stage instruction, the controller freezes the program counter and the fetch/decode register for one cycle. During that cycle it selects zero control values into the decode/execute register, so a harmless bubble moves forward. After the bubble, the pipeline's forwarding paths deliver the loaded value.

Branches are predicted not taken and resolved in decode. The controller compares the two register read words. It also forms the branch target: the incremented PC plus the sign-extended offset scaled by four. When a branch-if-equal is taken, the controller redirects the PC to that target and raises a flush. The flush makes the fetch/decode register load an all-zero instruction word, which encodes a no-op.

The datapath registers themselves sit outside this block. Only the steering signals and the branch target leave it.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_a`, the block drives `pc_write`=0, `ifid_write`=0 and `bubble_sel`=1 in that same cycle, unless a stall was already issued in the previous cycle.
- R2: The same stall happens when a nonzero `ex_dst` equals `id_src_b` instead of `id_src_a`.
- R3: With `ex_is_load`=0, or with no register match, the block drives `pc_write`=1, `ifid_write`=1 and `bubble_sel`=0.
- R4: An `ex_dst` of 0 never causes a stall, even when it matches a source index.
- R5: A stall lasts exactly one cycle. In the cycle after a stall, `bubble_sel` is 0 and `pc_write` is 1, even if the hazard inputs are unchanged.
- R6: When `id_is_branch`=1 and `rd_a`==`rd_b` with no stall, `pc_src`=1, `fetch_flush`=1 and `pc_write`=1. The flush means the fetch/decode instruction word is replaced by all zeros, a no-op.
- R7: When `id_is_branch`=0, or `rd_a`!=`rd_b`, `pc_src`=0 and `fetch_flush`=0.
- R8: `br_target` equals `pc_next_seq` plus the 16-bit `br_offset` sign-extended and shifted left by 2. This holds for positive and negative offsets.
- R9: When a stall and a taken branch coincide, the stall wins: `pc_src`=0 and `fetch_flush`=0. In the next cycle, with the stall spent, the same branch is taken.
- R10: Synchronous reset clears the stall history. A hazard present in the first cycle after reset therefore stalls. During reset with idle inputs, `pc_write`=1, `ifid_write`=1 and `bubble_sel`, `pc_src`, `fetch_flush` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| ex_dst | input | 5 | Destination register index of the load in execute |
| id_src_a | input | 5 | First source register index in decode |
| id_src_b | input | 5 | Second source register index in decode |
| id_is_branch | input | 1 | Decode holds a branch-if-equal |
| rd_a | input | 32 | First register read word in decode |
| rd_b | input | 32 | Second register read word in decode |
| pc_next_seq | input | 32 | Incremented PC of the decode instruction |
| br_offset | input | 16 | Branch offset field in words |
| pc_write | output | 1 | PC may update this cycle |
| ifid_write | output | 1 | Fetch/decode register may update this cycle |
| bubble_sel | output | 1 | Select zero controls into decode/execute |
| fetch_flush | output | 1 | Zero the fetch/decode instruction word |
| pc_src | output | 1 | Select branch target as next PC |
| br_target | output | 32 | Branch target address |

## Verification
The assertions assume the inputs come from a real pipeline. In particular, the one-cycle rule is judged on the outputs, whatever the execute-stage inputs do after a stall. Apart from that, the properties hold for arbitrary input values. The stimulus sets inputs at the falling edge and reads the combinational outputs shortly after. It holds hazard inputs across a rising edge only where the one-cycle rule or stall priority is under test. It returns to idle inputs between scenarios, so that each scenario starts with no stall history.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int OFF_W  = 16;

    typedef logic [REG_AW-1:0] reg_idx_t;
    typedef logic [XLEN-1:0]   word_t;

    // steering bundle produced by the controller
    typedef struct packed {
        logic pc_write;
        logic ifid_write;
        logic bubble_sel;
        logic fetch_flush;
        logic pc_src;
    } steer_t;

    // sign-extend a word offset and scale it to bytes
    function automatic word_t scaled_offset(input logic [OFF_W-1:0] off);
        return {{(XLEN-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    endfunction
endpackage

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic          ex_is_load,
    input  logic [AW-1:0] ex_dst,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    output logic          hazard
);
    logic dst_live;
    logic hit_a;
    logic hit_b;

    always_comb begin
        dst_live = (ex_dst != '0);
        hit_a    = (ex_dst == id_src_a);
        hit_b    = (ex_dst == id_src_b);
        hazard   = ex_is_load && dst_live && (hit_a || hit_b);
    end
endmodule

// File: rtl/hz_stall_guard.sv
module hz_stall_guard (
    input  logic clk,
    input  logic rst,
    input  logic hazard,
    output logic stall
);
    logic stalled_q;

    // a hazard seen right after a stall is already covered by that bubble
    assign stall = hazard && !stalled_q;

    always_ff @(posedge clk) begin
        if (rst) stalled_q <= 1'b0;
        else     stalled_q <= stall;
    end
endmodule

// File: rtl/hz_branch_resolve.sv
module hz_branch_resolve
    import hz_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int OW = OFF_W
) (
    input  logic          is_branch,
    input  logic          hold,
    input  logic [W-1:0]  rd_a,
    input  logic [W-1:0]  rd_b,
    input  logic [W-1:0]  pc_next_seq,
    input  logic [OW-1:0] offset,
    output logic          taken,
    output logic [W-1:0]  target
);
    logic equal;

    always_comb begin
        equal  = (rd_a == rd_b);
        taken  = is_branch && equal && !hold;
        target = pc_next_seq + scaled_offset(offset);
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic              id_is_branch,
    input  logic [XLEN-1:0]   rd_a,
    input  logic [XLEN-1:0]   rd_b,
    input  logic [XLEN-1:0]   pc_next_seq,
    input  logic [OFF_W-1:0]  br_offset,
    output logic              pc_write,
    output logic              ifid_write,
    output logic              bubble_sel,
    output logic              fetch_flush,
    output logic              pc_src,
    output logic [XLEN-1:0]   br_target
);
    logic   hazard;
    logic   stall;
    logic   taken;
    steer_t steer;

    hz_loaduse_detect #(.AW(REG_AW)) u_detect (
        .ex_is_load (ex_is_load),
        .ex_dst     (ex_dst),
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .hazard     (hazard)
    );

    hz_stall_guard u_guard (
        .clk    (clk),
        .rst    (rst),
        .hazard (hazard),
        .stall  (stall)
    );

    // stall has priority: a held branch is resolved again next cycle
    hz_branch_resolve #(.W(XLEN), .OW(OFF_W)) u_branch (
        .is_branch   (id_is_branch),
        .hold        (stall),
        .rd_a        (rd_a),
        .rd_b        (rd_b),
        .pc_next_seq (pc_next_seq),
        .offset      (br_offset),
        .taken       (taken),
        .target      (br_target)
    );

    always_comb begin
        steer.pc_write    = !stall;
        steer.ifid_write  = !stall;
        steer.bubble_sel  = stall;
        steer.fetch_flush = taken;
        steer.pc_src      = taken;
    end

    assign pc_write    = steer.pc_write;
    assign ifid_write  = steer.ifid_write;
    assign bubble_sel  = steer.bubble_sel;
    assign fetch_flush = steer.fetch_flush;
    assign pc_src      = steer.pc_src;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk
    import hz_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] ex_dst,
    input logic [REG_AW-1:0] id_src_a,
    input logic [REG_AW-1:0] id_src_b,
    input logic              id_is_branch,
    input logic [XLEN-1:0]   rd_a,
    input logic [XLEN-1:0]   rd_b,
    input logic              pc_write,
    input logic              ifid_write,
    input logic              bubble_sel,
    input logic              fetch_flush,
    input logic              pc_src
);
    // R1
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_sel |-> (ex_is_load && ((ex_dst == id_src_a) || (ex_dst == id_src_b))));

    // R1
    freeze_together_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_write == ifid_write) && (pc_write == !bubble_sel));

    // R4
    zero_dst_free_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == '0) |-> !bubble_sel);

    // R5
    single_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_sel |=> !bubble_sel);

    // R6
    taken_flushes_chk: assert property (@(posedge clk) disable iff (rst)
        pc_src |-> (fetch_flush && pc_write));

    // R7
    taken_needs_equal_chk: assert property (@(posedge clk) disable iff (rst)
        pc_src |-> (id_is_branch && (rd_a == rd_b)));

    // R9
    stall_beats_branch_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_sel |-> (!pc_src && !fetch_flush));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .ex_is_load   (ex_is_load),
    .ex_dst       (ex_dst),
    .id_src_a     (id_src_a),
    .id_src_b     (id_src_b),
    .id_is_branch (id_is_branch),
    .rd_a         (rd_a),
    .rd_b         (rd_b),
    .pc_write     (pc_write),
    .ifid_write   (ifid_write),
    .bubble_sel   (bubble_sel),
    .fetch_flush  (fetch_flush),
    .pc_src       (pc_src)
);

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        ex_is_load;
    logic [4:0]  ex_dst, id_src_a, id_src_b;
    logic        id_is_branch;
    logic [31:0] rd_a, rd_b, pc_next_seq;
    logic [15:0] br_offset;
    logic        pc_write, ifid_write, bubble_sel, fetch_flush, pc_src;
    logic [31:0] br_target;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pipe_hazard_ctrl i_pipe_hazard_ctrl (
        .clk(clk), .rst(rst), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_is_branch(id_is_branch),
        .rd_a(rd_a), .rd_b(rd_b), .pc_next_seq(pc_next_seq), .br_offset(br_offset),
        .pc_write(pc_write), .ifid_write(ifid_write), .bubble_sel(bubble_sel),
        .fetch_flush(fetch_flush), .pc_src(pc_src), .br_target(br_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // packs {pc_write, ifid_write, bubble_sel, fetch_flush, pc_src}
    function automatic logic [31:0] steer();
        return {27'd0, pc_write, ifid_write, bubble_sel, fetch_flush, pc_src};
    endfunction

    localparam logic [31:0] RUN   = 32'b11000;
    localparam logic [31:0] STALL = 32'b00100;
    localparam logic [31:0] TAKE  = 32'b11011;

    task automatic idle();
        @(negedge clk);
        ex_is_load = 0; ex_dst = 0; id_src_a = 0; id_src_b = 0;
        id_is_branch = 0; rd_a = 0; rd_b = 0; pc_next_seq = 0; br_offset = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle();
        #1 check("R10 reset outputs", steer(), RUN);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic t_stall_src_a();
        idle();
        ex_is_load = 1; ex_dst = 5'd7; id_src_a = 5'd7; id_src_b = 5'd3;
        #1 check("R1 stall on src a", steer(), STALL);
    endtask

    task automatic t_stall_src_b();
        idle();
        ex_is_load = 1; ex_dst = 5'd9; id_src_a = 5'd2; id_src_b = 5'd9;
        #1 check("R2 stall on src b", steer(), STALL);
    endtask

    task automatic t_no_stall();
        idle();
        ex_is_load = 0; ex_dst = 5'd4; id_src_a = 5'd4; id_src_b = 5'd4;
        #1 check("R3 match without load", steer(), RUN);
        ex_is_load = 1; ex_dst = 5'd4; id_src_a = 5'd5; id_src_b = 5'd6;
        #1 check("R3 load without match", steer(), RUN);
    endtask

    task automatic t_zero_dst();
        idle();
        ex_is_load = 1; ex_dst = 5'd0; id_src_a = 5'd0; id_src_b = 5'd0;
        #1 check("R4 zero destination", steer(), RUN);
    endtask

    task automatic t_one_cycle();
        idle();
        ex_is_load = 1; ex_dst = 5'd12; id_src_a = 5'd12; id_src_b = 5'd1;
        #1 check("R5 first cycle stalls", steer(), STALL);
        @(negedge clk);
        #1 check("R5 second cycle runs", steer(), RUN);
    endtask

    task automatic t_branch();
        idle();
        id_is_branch = 1; rd_a = 32'hDEAD_0001; rd_b = 32'hDEAD_0001;
        #1 check("R6 taken branch", steer(), TAKE);
        rd_b = 32'hDEAD_0002;
        #1 check("R7 unequal operands", steer(), RUN);
        id_is_branch = 0; rd_b = rd_a;
        #1 check("R7 equal but no branch", steer(), RUN);
    endtask

    task automatic t_target();
        idle();
        pc_next_seq = 32'h0000_0100; br_offset = 16'h0007;
        #1 check("R8 forward target", br_target, 32'h0000_0100 + 32'd28);
        br_offset = 16'hFFFE;
        #1 check("R8 backward target", br_target, 32'h0000_00F8);
        pc_next_seq = 32'h0001_0000; br_offset = 16'h8000;
        #1 check("R8 most negative", br_target, 32'h0001_0000 - 32'h0002_0000);
    endtask

    task automatic t_priority();
        idle();
        ex_is_load = 1; ex_dst = 5'd3; id_src_a = 5'd3; id_src_b = 5'd8;
        id_is_branch = 1; rd_a = 32'h55; rd_b = 32'h55;
        #1 check("R9 stall beats branch", steer(), STALL);
        @(negedge clk);
        #1 check("R9 branch taken after stall", steer(), TAKE);
    endtask

    task automatic t_reset_history();
        idle();
        rst = 1'b1;
        ex_is_load = 1; ex_dst = 5'd6; id_src_a = 5'd1; id_src_b = 5'd6;
        @(negedge clk) rst = 1'b0;
        #1 check("R10 stall right after reset", steer(), STALL);
        @(negedge clk);
        #1 check("R10 then one-cycle rule", steer(), RUN);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        t_reset();
        t_stall_src_a();
        t_stall_src_b();
        t_no_stall();
        t_zero_dst();
        t_one_cycle();
        t_branch();
        t_target();
        t_priority();
        t_reset_history();
        idle();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end
endmodule